// File: doc/BRIEF.md
# Coherent Real-Time-Clock Snapshot Reader

This controller pulls a complete calendar timestamp out of an external clock chip whose registers are reached one byte at a time through an index/data port. A clock that ticks while its fields are being read can yield a torn value, such as a minute rollover seen halfway through. The reader therefore reads the whole field set twice and accepts the result only when two conditions hold. First, the clock's update-in-progress flag must be clear between the two passes. Second, both passes must return identical bytes.

A single `start` pulse begins a sequence. The reader first fetches the configuration status register to learn whether the clock stores its fields as packed BCD or as plain binary. It then loops over field pass, flag check and confirm pass until the snapshot is coherent. It decodes BCD when that encoding is in use and adds the century base to the two-digit year. The finished result is presented with a one-cycle `done` pulse.

Each register access is a one-cycle `req_valid` pulse that carries `req_index`. The clock side answers at some later cycle with a one-cycle `rsp_valid` pulse and the byte on `rsp_data`.

Top module: `rtc_snap_reader`

## Requirements
- R1: Out of reset `done` and `req_valid` are low and all six result outputs read zero.
- R2: A `start` pulse while idle produces, in the following cycle, a `req_valid` pulse whose `req_index` is 0x0B (the configuration status register).
- R3: Per attempt the access order is 0x0B once per sequence, then the fields 0x00 seconds, 0x02 minutes, 0x04 hours, 0x07 day, 0x08 month, 0x09 year, then 0x0A (update status), then the same six field indices again.
- R4: `req_valid` is high for exactly one cycle per access, is only raised while a sequence is active, and no new access is issued before the previous one's `rsp_valid`.
- R5: If bit 7 of the byte returned from index 0x0A is 1, the confirm pass is skipped and the field pass restarts at index 0x00.
- R6: If any confirm-pass byte differs from the same field of the preceding field pass, including the year (the last byte), the sequence restarts at index 0x00 without re-reading 0x0B.
- R7: After a matching confirm pass, `done` is high for exactly one cycle, in the cycle after the last `rsp_valid`, with the results valid in that same cycle.
- R8: When bit 2 of the byte returned from index 0x0B is 0, each field is converted as (high nibble × 10) + low nibble.
- R9: When bit 2 of that byte is 1, the field bytes pass unchanged.
- R10: `year_o` equals the decoded year byte plus 2000, on 12 bits.
- R11: A `start` pulse while a sequence is active, including one in the same cycle as the final response, is ignored: no extra access and no extra `done`.
- R12: The result outputs hold their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a snapshot sequence (idle only) |
| req_valid | output | 1 | One-cycle register access request |
| req_index | output | 8 | Register index of the request |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_data | input | 8 | Register byte returned with `rsp_valid` |
| done | output | 1 | One-cycle pulse: results valid |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| day_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 12 | Full year |

## Verification
Two cases can land on the same clock edge. In the first, the final confirm-pass response completes acceptance while a new `start` arrives. The bench's clock model raises `start` in the very cycle it delivers the last byte. It then requires exactly one `done` and no further accesses in the following cycles. In the second, the comparison must catch a mismatch in the byte arriving on that edge rather than in stored state. The model changes the year register just before the confirm pass reads it, and the bench expects a full retry: 27 accesses and the new year.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int NFIELDS = 6;
    localparam int FW      = $clog2(NFIELDS);
    localparam int IW      = 8;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    localparam logic [IW-1:0] IDX_UPD_STAT = 8'h0A;
    localparam logic [IW-1:0] IDX_CFG_STAT = 8'h0B;
    localparam int UPD_BIT = 7;
    localparam int BIN_BIT = 2;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CFG   = 3'd1,
        PH_FIRST = 3'd2,
        PH_UPD   = 3'd3,
        PH_CONF  = 3'd4
    } phase_e;

    function automatic logic [IW-1:0] field_index(input logic [FW-1:0] k);
        logic [IW-1:0] r;
        case (k)
            3'd0:    r = 8'h00;
            3'd1:    r = 8'h02;
            3'd2:    r = 8'h04;
            3'd3:    r = 8'h07;
            3'd4:    r = 8'h08;
            3'd5:    r = 8'h09;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_snap_index.sv
module rtc_snap_index
    import rtc_snap_pkg::*;
(
    input  phase_e          phase,
    input  logic [FW-1:0]   fld,
    output logic [IW-1:0]   idx
);
    always_comb begin
        case (phase)
            PH_CFG:            idx = IDX_CFG_STAT;
            PH_UPD:            idx = IDX_UPD_STAT;
            PH_FIRST, PH_CONF: idx = field_index(fld);
            default:           idx = '0;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_to_bin.sv
module rtc_bcd_to_bin #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         en,
    output logic [W-1:0] val
);
    localparam int HW = W - 4;

    logic [W-1:0] hi;
    logic [W-1:0] lo;

    always_comb begin
        hi  = W'(raw[W-1 -: HW]);
        lo  = W'(raw[3:0]);
        val = en ? W'(hi * W'(10) + lo) : raw;
    end
endmodule

// File: rtl/rtc_snap_cmp.sv
module rtc_snap_cmp #(
    parameter int N = 6,
    parameter int W = 8
) (
    input  logic [N-1:0][W-1:0] a,
    input  logic [N-1:0][W-1:0] b,
    output logic                eq
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_field
        assign hit[g] = (a[g] == b[g]);
    end

    assign eq = &hit;
endmodule

// File: rtl/rtc_snap_reader.sv
module rtc_snap_reader
    import rtc_snap_pkg::*;
#(
    parameter int DW        = 8,
    parameter int YW        = 12,
    parameter int YEAR_BASE = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          req_valid,
    output logic [IW-1:0] req_index,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          done,
    output logic [DW-1:0] sec_o,
    output logic [DW-1:0] min_o,
    output logic [DW-1:0] hour_o,
    output logic [DW-1:0] day_o,
    output logic [DW-1:0] mon_o,
    output logic [YW-1:0] year_o
);
    localparam logic [FW-1:0] LAST = FW'(NFIELDS - 1);

    typedef struct packed {
        phase_e                     phase;
        logic [FW-1:0]              fld;
        logic                       issue;
        logic                       bin_mode;
        logic [NFIELDS-1:0][DW-1:0] t1;
        logic [NFIELDS-1:0][DW-1:0] t2;
        logic                       done;
        logic [NFIELDS-2:0][DW-1:0] res;
        logic [YW-1:0]              year;
    } st_t;

    st_t st_d, st_q;

    logic                       rsp_ok;
    logic                       busy;
    logic                       match;
    logic [NFIELDS-1:0][DW-1:0] cand;
    logic [NFIELDS-1:0][DW-1:0] conv;

    // A response only counts once the request pulse has gone.
    assign rsp_ok = rsp_valid && !st_q.issue;
    assign busy   = (st_q.phase != PH_IDLE);

    // Confirm pass as it stands including the byte arriving now.
    always_comb begin
        cand       = st_q.t2;
        cand[LAST] = rsp_data;
    end

    rtc_snap_cmp #(.N(NFIELDS), .W(DW)) u_cmp (
        .a  (cand),
        .b  (st_q.t1),
        .eq (match)
    );

    for (genvar g = 0; g < NFIELDS; g++) begin : g_conv
        rtc_bcd_to_bin #(.W(DW)) u_conv (
            .raw (st_q.t1[g]),
            .en  (!st_q.bin_mode),
            .val (conv[g])
        );
    end

    rtc_snap_index u_index (
        .phase (st_q.phase),
        .fld   (st_q.fld),
        .idx   (req_index)
    );

    always_comb begin
        st_d       = st_q;
        st_d.issue = 1'b0;
        st_d.done  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_CFG;
                    st_d.issue = 1'b1;
                end
            end
            PH_CFG: begin
                if (rsp_ok) begin
                    st_d.bin_mode = rsp_data[BIN_BIT];
                    st_d.phase    = PH_FIRST;
                    st_d.fld      = '0;
                    st_d.issue    = 1'b1;
                end
            end
            PH_FIRST: begin
                if (rsp_ok) begin
                    st_d.t1[st_q.fld] = rsp_data;
                    st_d.issue        = 1'b1;
                    if (st_q.fld == LAST) begin
                        st_d.phase = PH_UPD;
                    end else begin
                        st_d.fld = st_q.fld + 1'b1;
                    end
                end
            end
            PH_UPD: begin
                if (rsp_ok) begin
                    st_d.fld   = '0;
                    st_d.issue = 1'b1;
                    st_d.phase = rsp_data[UPD_BIT] ? PH_FIRST : PH_CONF;
                end
            end
            PH_CONF: begin
                if (rsp_ok) begin
                    st_d.t2[st_q.fld] = rsp_data;
                    if (st_q.fld != LAST) begin
                        st_d.fld   = st_q.fld + 1'b1;
                        st_d.issue = 1'b1;
                    end else if (match) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                        for (int k = 0; k < NFIELDS - 1; k++) begin
                            st_d.res[k] = conv[k];
                        end
                        st_d.year = YW'(conv[F_YEAR]) + YW'(YEAR_BASE);
                    end else begin
                        st_d.phase = PH_FIRST;
                        st_d.fld   = '0;
                        st_d.issue = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid = st_q.issue;
    assign done      = st_q.done;
    assign sec_o     = st_q.res[F_SEC];
    assign min_o     = st_q.res[F_MIN];
    assign hour_o    = st_q.res[F_HOUR];
    assign day_o     = st_q.res[F_DAY];
    assign mon_o     = st_q.res[F_MON];
    assign year_o    = st_q.year;

endmodule

// File: rtl/rtc_snap_reader_chk.sv
module rtc_snap_reader_chk #(
    parameter int DW        = 8,
    parameter int YW        = 12,
    parameter int YEAR_BASE = 2000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          req_valid,
    input logic [7:0]    req_index,
    input logic          done,
    input logic [DW-1:0] sec_o,
    input logic [DW-1:0] min_o,
    input logic [DW-1:0] hour_o,
    input logic [DW-1:0] day_o,
    input logic [DW-1:0] mon_o,
    input logic [YW-1:0] year_o
);
    p_start_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (req_valid && req_index == 8'h0B));

    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_year_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (year_o >= YW'(YEAR_BASE)));

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({sec_o, min_o, hour_o, day_o, mon_o, year_o}));
endmodule

bind rtc_snap_reader rtc_snap_reader_chk #(
    .DW(DW), .YW(YW), .YEAR_BASE(YEAR_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .req_valid (req_valid),
    .req_index (req_index),
    .done      (done),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .day_o     (day_o),
    .mon_o     (mon_o),
    .year_o    (year_o)
);

// File: tb/rtc_snap_reader_tb.sv
module rtc_snap_reader_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        req_valid;
    logic [7:0]  req_index;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        done;
    logic [7:0]  sec_o, min_o, hour_o, day_o, mon_o;
    logic [11:0] year_o;

    always #4 clk = ~clk;

    rtc_snap_reader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_index(req_index),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .done(done), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .day_o(day_o), .mon_o(mon_o), .year_o(year_o)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] regs [0:15];
    logic [7:0] log_idx [0:63];
    logic [7:0] cur_idx;
    int lat        = 1;
    int rd_cnt     = 0;
    int uip_left   = 0;
    int mut_at     = -1;
    int mut_reg    = 0;
    logic [7:0] mut_val = 8'h00;
    int start_at   = -1;
    int overlap    = 0;
    int done_cnt   = 0;
    bit resp_start = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int v, input bit bin);
        return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] exp_idx(input int k);
        logic [7:0] f;
        int j;
        if (k == 0) return 8'h0B;
        if (k == 7) return 8'h0A;
        j = (k < 7) ? k - 1 : k - 8;
        case (j)
            0: f = 8'h00; 1: f = 8'h02; 2: f = 8'h04;
            3: f = 8'h07; 4: f = 8'h08; default: f = 8'h09;
        endcase
        return f;
    endfunction

    // Clock chip model: answers each request after lat cycles.
    initial begin
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (resp_start) begin
                start      = 1'b0;
                resp_start = 1'b0;
            end
            if (done) done_cnt++;
            if (req_valid) begin
                cur_idx = req_index;
                if (rd_cnt < 64) log_idx[rd_cnt] = req_index;
                for (int w = 0; w < lat; w++) begin
                    @(negedge clk);
                    if (req_valid) overlap++;
                end
                rsp_data = regs[cur_idx[3:0]];
                if (cur_idx == 8'h0A && uip_left > 0) begin
                    rsp_data = rsp_data | 8'h80;
                    uip_left--;
                end
                rsp_valid = 1'b1;
                rd_cnt++;
                if (rd_cnt == start_at) begin
                    start      = 1'b1;
                    resp_start = 1'b1;
                end
                if (rd_cnt == mut_at) regs[mut_reg] = mut_val;
            end
        end
    end

    task automatic load(input int s, input int mi, input int h, input int d,
                        input int mo, input int y, input bit bin);
        regs[0]  = enc(s, bin);  regs[2] = enc(mi, bin); regs[4] = enc(h, bin);
        regs[7]  = enc(d, bin);  regs[8] = enc(mo, bin); regs[9] = enc(y, bin);
        regs[10] = 8'h26;
        regs[11] = bin ? 8'h06 : 8'h02;
    endtask

    task automatic run(input int s, input int mi, input int h, input int d,
                       input int mo, input int y, input int e_reads,
                       input string req, input bit chk_first);
        int n;
        rd_cnt   = 0;
        done_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (chk_first)   // R2
            chk(req_valid && req_index == 8'h0B, "R2", "first access",
                {req_valid, req_index}, {1'b1, 8'h0B});
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, "done seen", done, 1);
        chk({sec_o, min_o, hour_o, day_o, mon_o} ==
            {8'(s), 8'(mi), 8'(h), 8'(d), 8'(mo)}, req, "fields",
            {sec_o, min_o, hour_o, day_o, mon_o},
            {8'(s), 8'(mi), 8'(h), 8'(d), 8'(mo)});
        chk(year_o == 12'(y + 2000), "R10", "year", year_o, y + 2000);
        @(negedge clk);
        chk(!done, "R7", "done one cycle", done, 0);
        chk(rd_cnt == e_reads, req, "access count", rd_cnt, e_reads);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        start = 1'b0;
        rst_n = 1'b0;
        for (int k = 0; k < 16; k++) regs[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!done && !req_valid, "R1", "reset strobes", {done, req_valid}, 0);
        chk({sec_o, min_o, hour_o, day_o, mon_o, year_o} == '0, "R1",
            "reset results", {sec_o, min_o, hour_o, day_o, mon_o, year_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 access order on a clean BCD run, also R8
        load(59, 59, 23, 31, 12, 99, 1'b0);
        run(59, 59, 23, 31, 12, 99, 14, "R8", 1'b1);
        for (int k = 0; k < 14; k++)
            chk(log_idx[k] == exp_idx(k), "R3", "access index", log_idx[k], exp_idx(k));

        // R12 results hold after registers change
        load(1, 1, 1, 1, 1, 1, 1'b0);
        repeat (20) @(negedge clk);
        chk({sec_o, min_o, year_o} == {8'd59, 8'd59, 12'd2099}, "R12", "hold",
            {sec_o, min_o, year_o}, {8'd59, 8'd59, 12'd2099});

        // R8 / R9 sweep over both encodings
        for (int i = 0; i < 100; i++) begin
            for (int m = 0; m < 2; m++) begin
                lat = 1 + (i % 3);
                load(i % 60, (i * 7) % 60, i % 24, 1 + i % 31, 1 + i % 12, i, m[0]);
                run(i % 60, (i * 7) % 60, i % 24, 1 + i % 31, 1 + i % 12, i, 14,
                    m[0] ? "R9" : "R8", 1'b0);
            end
        end
        lat = 2;

        // R5 update flag seen twice
        load(30, 45, 12, 15, 6, 24, 1'b0);
        uip_left = 2;
        run(30, 45, 12, 15, 6, 24, 28, "R5", 1'b0);
        chk(log_idx[8] == 8'h00 && log_idx[15] == 8'h00, "R5", "restart index",
            {log_idx[8], log_idx[15]}, 16'h0000);

        // R6 minutes change during confirm pass
        load(30, 45, 12, 15, 6, 24, 1'b0);
        mut_at = 9; mut_reg = 2; mut_val = enc(46, 1'b0);
        run(30, 46, 12, 15, 6, 24, 27, "R6", 1'b0);
        chk(log_idx[14] == 8'h00, "R6", "no cfg reread", log_idx[14], 8'h00);

        // R6 last byte (year) differs
        load(30, 45, 12, 15, 6, 24, 1'b0);
        mut_at = 13; mut_reg = 9; mut_val = enc(25, 1'b0);
        run(30, 45, 12, 15, 6, 25, 27, "R6", 1'b0);
        mut_at = -1;

        // R11 start during field pass
        load(10, 20, 5, 3, 4, 7, 1'b1);
        start_at = 5;
        run(10, 20, 5, 3, 4, 7, 14, "R11", 1'b0);

        // R11 start together with the final response
        start_at = 14;
        run(10, 20, 5, 3, 4, 7, 14, "R11", 1'b0);
        start_at = -1;
        repeat (12) @(negedge clk);
        chk(rd_cnt == 14, "R11", "no extra access", rd_cnt, 14);
        chk(done_cnt == 1, "R11", "single done", done_cnt, 1);

        chk(overlap == 0, "R4", "access before response", overlap, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule